// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block keeps the state of a small set of prioritized exceptions and picks the one the processor should take next. Every vector has a priority, an enable flag, a pending flag and an active flag. Vectors 1 to 3 are fixed system exceptions with the negative priorities -3, -2 and -1. They are always enabled, and software cannot change them. All higher vectors carry an 8-bit priority that software can program. Vector 0 is reserved and never becomes pending.

The processor side raises pend requests, acknowledges the best pending vector and retires handlers by vector number. Each completion reports whether the handler was the last one active. A programmable split divides every configurable priority into a group part and a subpriority part. Preemption compares group parts only. The subpriority only orders pending vectors of equal group.

Top module: `nvic_ctrl`

## Requirements
- R1: A pend request on vector 1 to NUM_VEC-1 sets that vector's pending flag, and a request on vector 0 is ignored. `pend_valid_o` is high when at least one vector is both enabled and pending. `pend_vec_o` names the enabled pending vector with the numerically lowest full priority; on equal priority the lower vector number wins. The outputs reflect a request from the clock edge that registers it.
- R2: Vectors 1, 2 and 3 have the fixed priorities -3, -2 and -1 and are always enabled. Priority and enable writes addressed to them are ignored.
- R3: The split value s (0 to 7) clears the low s bits of a configurable priority to form its group priority; negative priorities keep their value. `pend_grp_o` shows the candidate's group priority under the current split.
- R4: `exec_prio_o` is the lowest group priority among active vectors, or 256 when no vector is active.
- R5: An acknowledge with a candidate present clears that vector's pending flag, sets its active flag and loads it into `cur_vec_o`. An acknowledge with no candidate changes nothing.
- R6: `take_o` is high exactly when a candidate exists and its group priority is strictly lower than `exec_prio_o`, combinationally from the current state.
- R7: One cycle after a completion request, `cmpl_done_o` pulses and `cmpl_stat_o` holds the result. The result is 2'b11 (-1) if the vector was not active. Otherwise the vector's active flag clears and the result is 2'b01 (1) if it was the only active vector, or 2'b00 (0) if another vector is still active.
- R8: `rdy_o` is high for the queried vector when it is enabled and its group priority is strictly lower than `exec_prio_o`.
- R9: After reset no vector is pending or active, every configurable vector is disabled with priority 0, the split is 0 and `cmpl_done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_valid_i | input | 1 | Pend request strobe |
| pend_num_i | input | VW | Vector to make pending |
| ack_i | input | 1 | Take the current candidate |
| cmpl_valid_i | input | 1 | Completion request strobe |
| cmpl_vec_i | input | VW | Vector being completed |
| en_we_i | input | 1 | Enable write strobe |
| en_vec_i | input | VW | Vector for enable write |
| en_val_i | input | 1 | Enable value |
| prio_we_i | input | 1 | Priority write strobe |
| prio_vec_i | input | VW | Vector for priority write |
| prio_val_i | input | 8 | Priority value |
| split_we_i | input | 1 | Split write strobe |
| split_val_i | input | 3 | Number of subpriority bits |
| rdy_vec_i | input | VW | Vector for readiness query |
| rdy_o | output | 1 | Queried vector could preempt now |
| pend_valid_o | output | 1 | A candidate exists |
| pend_vec_o | output | VW | Candidate vector |
| pend_grp_o | output | 10 | Candidate group priority, signed |
| exec_prio_o | output | 10 | Execution priority, signed |
| take_o | output | 1 | Take-exception request |
| cur_vec_o | output | VW | Last acknowledged vector |
| cmpl_done_o | output | 1 | Completion result valid |
| cmpl_stat_o | output | 2 | Completion result, signed |

## Verification
Pend, acknowledge and register writes are due one edge after they are driven. `pend_vec_o`, `pend_grp_o`, `exec_prio_o`, `take_o` and `rdy_o` depend on the stored state only through logic, so the bench samples them at the falling edge that follows the registering edge. The readiness query is combinational, so the bench checks it a short delay after setting the query vector. Completion results appear one edge after the request. A scoreboard queue holds the expected result of each request, and a monitor pops and compares an entry each time `cmpl_done_o` is high at a falling edge.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
  typedef logic signed [9:0] prio_t;
  localparam prio_t PRIO_IDLE = 10'sd256;

  function automatic prio_t grp_of(prio_t p, logic [2:0] s);
    prio_t m;
    m = prio_t'(10'h3ff << s);
    return (p < 0) ? p : (p & m);
  endfunction
endpackage

// File: rtl/exc_state_array.sv
module exc_state_array
  import nvic_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_set_i,
  input  logic [VW-1:0] pend_num_i,
  input  logic          ack_i,
  input  logic [VW-1:0] ack_vec_i,
  input  logic          clr_i,
  input  logic [VW-1:0] clr_vec_i,
  input  logic          en_we_i,
  input  logic [VW-1:0] en_vec_i,
  input  logic          en_val_i,
  input  logic          prio_we_i,
  input  logic [VW-1:0] prio_vec_i,
  input  logic [7:0]    prio_val_i,
  output prio_t         prio_o [NUM_VEC],
  output logic [NUM_VEC-1:0] en_o,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] act_o
);
  localparam int NUM_FIXED = 3;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam logic [VW-1:0] VID = VW'(v);
    if (v == 0) begin : g_rsvd
      assign prio_o[v] = PRIO_IDLE;
      assign en_o[v]   = 1'b0;
      assign pend_o[v] = 1'b0;
      assign act_o[v]  = 1'b0;
    end else begin : g_live
      logic pend_q, act_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= 1'b0;
          act_q  <= 1'b0;
        end else begin
          if (ack_i && ack_vec_i == VID) pend_q <= 1'b0;
          if (pend_set_i && pend_num_i == VID) pend_q <= 1'b1;
          if (clr_i && clr_vec_i == VID) act_q <= 1'b0;
          if (ack_i && ack_vec_i == VID) act_q <= 1'b1;
        end
      end
      assign pend_o[v] = pend_q;
      assign act_o[v]  = act_q;

      if (v <= NUM_FIXED) begin : g_fixed
        assign prio_o[v] = prio_t'(v) - 10'sd4;
        assign en_o[v]   = 1'b1;
      end else begin : g_cfg
        logic [7:0] prio_q;
        logic       en_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            prio_q <= '0;
            en_q   <= 1'b0;
          end else begin
            if (prio_we_i && prio_vec_i == VID) prio_q <= prio_val_i;
            if (en_we_i && en_vec_i == VID) en_q <= en_val_i;
          end
        end
        assign prio_o[v] = prio_t'({2'b00, prio_q});
        assign en_o[v]   = en_q;
      end
    end
  end
endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import nvic_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] valid_i,
  input  prio_t              key_i [NUM_VEC],
  output logic               found_o,
  output logic [VW-1:0]      idx_o,
  output prio_t              key_o
);
  // strict compare keeps the lower index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    key_o   = PRIO_IDLE;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (valid_i[i] && (!found_o || key_i[i] < key_o)) begin
        found_o = 1'b1;
        idx_o   = VW'(i);
        key_o   = key_i[i];
      end
    end
  end
endmodule

// File: rtl/nvic_ctrl.sv
module nvic_ctrl
  import nvic_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_valid_i,
  input  logic [VW-1:0] pend_num_i,
  input  logic          ack_i,
  input  logic          cmpl_valid_i,
  input  logic [VW-1:0] cmpl_vec_i,
  input  logic          en_we_i,
  input  logic [VW-1:0] en_vec_i,
  input  logic          en_val_i,
  input  logic          prio_we_i,
  input  logic [VW-1:0] prio_vec_i,
  input  logic [7:0]    prio_val_i,
  input  logic          split_we_i,
  input  logic [2:0]    split_val_i,
  input  logic [VW-1:0] rdy_vec_i,
  output logic          rdy_o,
  output logic          pend_valid_o,
  output logic [VW-1:0] pend_vec_o,
  output logic signed [9:0] pend_grp_o,
  output logic signed [9:0] exec_prio_o,
  output logic          take_o,
  output logic [VW-1:0] cur_vec_o,
  output logic          cmpl_done_o,
  output logic [1:0]    cmpl_stat_o
);
  prio_t              prio_w [NUM_VEC];
  prio_t              grp_w  [NUM_VEC];
  logic [NUM_VEC-1:0] en_w, pend_w, act_w;
  logic [2:0]         split_q;
  logic               do_ack;
  logic               act_found;
  logic [VW-1:0]      act_idx;
  prio_t              act_key, cand_prio;

  assign do_ack = ack_i && pend_valid_o;

  exc_state_array #(.NUM_VEC(NUM_VEC), .VW(VW)) u_state (
    .clk_i, .rst_ni,
    .pend_set_i (pend_valid_i),
    .pend_num_i,
    .ack_i      (do_ack),
    .ack_vec_i  (pend_vec_o),
    .clr_i      (cmpl_valid_i),
    .clr_vec_i  (cmpl_vec_i),
    .en_we_i, .en_vec_i, .en_val_i,
    .prio_we_i, .prio_vec_i, .prio_val_i,
    .prio_o     (prio_w),
    .en_o       (en_w),
    .pend_o     (pend_w),
    .act_o      (act_w)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_grp
    assign grp_w[v] = grp_of(prio_w[v], split_q);
  end

  // full priority orders candidates, so subpriority breaks group ties
  exc_pick #(.NUM_VEC(NUM_VEC), .VW(VW)) u_pend_pick (
    .valid_i (en_w & pend_w),
    .key_i   (prio_w),
    .found_o (pend_valid_o),
    .idx_o   (pend_vec_o),
    .key_o   (cand_prio)
  );

  exc_pick #(.NUM_VEC(NUM_VEC), .VW(VW)) u_act_pick (
    .valid_i (act_w),
    .key_i   (grp_w),
    .found_o (act_found),
    .idx_o   (act_idx),
    .key_o   (act_key)
  );

  assign pend_grp_o  = pend_valid_o ? grp_of(cand_prio, split_q) : PRIO_IDLE;
  assign exec_prio_o = act_found ? act_key : PRIO_IDLE;
  assign take_o      = pend_valid_o && (pend_grp_o < exec_prio_o);

  always_comb begin
    rdy_o = 1'b0;
    for (int i = 0; i < NUM_VEC; i++)
      if (rdy_vec_i == VW'(i)) rdy_o = en_w[i] && (grp_w[i] < exec_prio_o);
  end

  logic cmpl_hit;
  always_comb begin
    cmpl_hit = 1'b0;
    for (int i = 0; i < NUM_VEC; i++)
      if (cmpl_vec_i == VW'(i)) cmpl_hit = act_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      split_q     <= '0;
      cur_vec_o   <= '0;
      cmpl_done_o <= 1'b0;
      cmpl_stat_o <= '0;
    end else begin
      if (split_we_i) split_q <= split_val_i;
      if (do_ack) cur_vec_o <= pend_vec_o;
      cmpl_done_o <= cmpl_valid_i;
      if (cmpl_valid_i) begin
        if (!cmpl_hit) cmpl_stat_o <= 2'b11;
        else cmpl_stat_o <= ($countones(act_w) == 1) ? 2'b01 : 2'b00;
      end
    end
  end
endmodule

// File: rtl/nvic_checker.sv
module nvic_checker #(
  parameter int NUM_VEC = 48,
  parameter int VW      = $clog2(NUM_VEC)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          cmpl_valid_i,
  input logic          prio_we_i,
  input logic          split_we_i,
  input logic          pend_valid_o,
  input logic [VW-1:0] pend_vec_o,
  input logic signed [9:0] pend_grp_o,
  input logic signed [9:0] exec_prio_o,
  input logic          take_o,
  input logic [VW-1:0] cur_vec_o,
  input logic          cmpl_done_o
);
  a_r1_no_vec0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> pend_vec_o != '0);
  a_r4_exec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_prio_o >= -10'sd3) && (exec_prio_o <= 10'sd256));
  a_r5_ack_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_valid_o) |=> cur_vec_o == $past(pend_vec_o));
  a_r5_ack_raises_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_valid_o && !cmpl_valid_i && !prio_we_i && !split_we_i)
    |=> exec_prio_o <= $past(pend_grp_o));
  a_r6_take_needs_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> pend_valid_o);
  a_r7_cmpl_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i |=> cmpl_done_o);
endmodule

bind nvic_ctrl nvic_checker #(.NUM_VEC(NUM_VEC), .VW(VW)) u_nvic_checker (.*);

// File: tb/test_nvic_ctrl.sv
module test_nvic_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 48;
  localparam int VW = $clog2(NUM_VEC);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pend_valid_i = 0, ack_i = 0, cmpl_valid_i = 0, en_we_i = 0, en_val_i = 0;
  logic prio_we_i = 0, split_we_i = 0;
  logic [VW-1:0] pend_num_i = '0, cmpl_vec_i = '0, en_vec_i = '0, prio_vec_i = '0, rdy_vec_i = '0;
  logic [7:0] prio_val_i = '0;
  logic [2:0] split_val_i = '0;
  logic rdy_o, pend_valid_o, take_o, cmpl_done_o;
  logic [VW-1:0] pend_vec_o, cur_vec_o;
  logic signed [9:0] pend_grp_o, exec_prio_o;
  logic [1:0] cmpl_stat_o;

  int n_chk = 0, n_fail = 0;
  logic [1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nvic_ctrl #(.NUM_VEC(NUM_VEC)) i_nvic_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
    pend_valid_i = 0; ack_i = 0; cmpl_valid_i = 0; en_we_i = 0;
    prio_we_i = 0; split_we_i = 0;
  endtask

  task automatic cfg(input int v, input int p, input bit en);
    prio_we_i = 1; prio_vec_i = VW'(v); prio_val_i = 8'(p);
    en_we_i = 1; en_vec_i = VW'(v); en_val_i = en;
    cyc();
  endtask

  task automatic pend(input int v);
    pend_valid_i = 1; pend_num_i = VW'(v); cyc();
  endtask

  task automatic cmpl(input int v, input logic [1:0] exp);
    exp_q.push_back(exp);
    cmpl_valid_i = 1; cmpl_vec_i = VW'(v); cyc();
  endtask

  task automatic split(input int s);
    split_we_i = 1; split_val_i = 3'(s); cyc();
  endtask

  task automatic chk_cand(input string req, input int v, input int g, input bit t);
    chk(pend_valid_o && pend_vec_o == VW'(v), req, int'(pend_vec_o), v);
    chk(pend_grp_o == 10'(g), req, int'(pend_grp_o), g);
    chk(take_o == t, req, int'(take_o), int'(t));
  endtask

  task automatic chk_rdy(input string req, input int v, input bit e);
    rdy_vec_i = VW'(v); #1;
    chk(rdy_o == e, req, int'(rdy_o), int'(e));
  endtask

  // scoreboard monitor for completion results (R7)
  always @(negedge clk_i) begin
    if (rst_ni && cmpl_done_o) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected result", int'(cmpl_stat_o), -1);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(cmpl_stat_o == e, "R7 status", int'(cmpl_stat_o), int'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R9 reset state
    chk(!pend_valid_o, "R9 no pending", int'(pend_valid_o), 0);
    chk(exec_prio_o == 10'sd256, "R9 exec idle", int'(exec_prio_o), 256);
    chk(!take_o, "R9 no take", int'(take_o), 0);
    chk(!cmpl_done_o, "R9 no done", int'(cmpl_done_o), 0);
    chk_rdy("R9 vec 20 disabled", 20, 0);

    cfg(20, 8'h40, 1);
    pend(20);
    chk_cand("R1 single candidate", 20, 64, 1);          // R6 idle exec
    pend(0);
    chk_cand("R1 vector 0 ignored", 20, 64, 1);
    cfg(17, 8'h40, 1);
    pend(17);
    chk_cand("R1 tie lower number", 17, 64, 1);
    cfg(30, 8'h41, 1);
    pend(30);
    chk_cand("R1 lowest priority", 17, 64, 1);

    ack_i = 1; cyc();
    chk(cur_vec_o == VW'(17), "R5 cur vec", int'(cur_vec_o), 17);
    chk(exec_prio_o == 10'sd64, "R4 exec after ack", int'(exec_prio_o), 64);
    chk_cand("R6 equal group no take", 20, 64, 0);

    prio_we_i = 1; prio_vec_i = VW'(20); prio_val_i = 8'h3f; cyc();
    chk_cand("R6 better group take", 20, 63, 1);
    split(4);
    chk_cand("R3 split masks candidate", 20, 48, 1);
    prio_we_i = 1; prio_vec_i = VW'(20); prio_val_i = 8'h45; cyc();
    chk_cand("R3 subpriority orders group tie", 30, 64, 0);
    chk_rdy("R8 same group not ready", 30, 0);
    split(0);
    chk_cand("R3 split zero", 30, 65, 0);
    prio_we_i = 1; prio_vec_i = VW'(30); prio_val_i = 8'h10; cyc();
    chk_cand("R6 preempt after reprio", 30, 16, 1);
    chk_rdy("R8 ready", 30, 1);
    en_we_i = 1; en_vec_i = VW'(30); en_val_i = 0; cyc();
    chk_rdy("R8 disabled not ready", 30, 0);
    chk_cand("R1 disabled skipped", 20, 69, 0);

    // R2 fixed vectors ignore writes
    cfg(2, 8'hff, 0);
    pend(2);
    chk_cand("R2 fixed prio kept", 2, -2, 1);
    ack_i = 1; cyc();
    chk(exec_prio_o == -10'sd2, "R4 negative exec", int'(exec_prio_o), -2);
    chk(cur_vec_o == VW'(2), "R5 cur vec fixed", int'(cur_vec_o), 2);
    pend(3);
    chk_cand("R2 fixed -1 waits", 3, -1, 0);
    pend(1);
    chk_cand("R2 fixed -3 preempts", 1, -3, 1);

    // R7 completion
    cmpl(5, 2'b11);
    cmpl(2, 2'b00);
    chk(exec_prio_o == 10'sd64, "R4 exec back", int'(exec_prio_o), 64);
    cmpl(17, 2'b01);
    chk(exec_prio_o == 10'sd256, "R4 exec idle again", int'(exec_prio_o), 256);
    cmpl(17, 2'b11);
    // R5 ack without candidate changes nothing
    en_we_i = 1; en_vec_i = VW'(20); en_val_i = 0; cyc();
    ack_i = 1; pend_valid_i = 0; cyc();
    // vectors 1 and 3 still pending: candidate 1, ack takes it
    chk(pend_vec_o == VW'(3), "R5 ack took 1", int'(pend_vec_o), 3);
    chk(cur_vec_o == VW'(1), "R5 cur vec 1", int'(cur_vec_o), 1);
    ack_i = 1; cyc();
    ack_i = 1; cyc();
    chk(cur_vec_o == VW'(3), "R5 empty ack keeps cur", int'(cur_vec_o), 3);
    chk(!pend_valid_o, "R5 none pending", int'(pend_valid_o), 0);
    cyc();
    chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule